// File: doc/BRIEF.md
# Out-of-Order Resource Allocator

This block is the allocation stage of an out-of-order core. Each cycle it is offered a group of up to four micro-ops in program order. Every micro-op it accepts receives a reorder buffer (ROB) entry and a reservation station (RS) entry. A load also receives a load buffer entry, and a store also receives a store buffer entry. A micro-op is accepted only when every pool it needs has room, so acceptance always forms a prefix of the group. The destination register of each accepted micro-op is renamed to its ROB tag.

For every source operand the block reports whether the value will come from an in-flight ROB entry, and which one, or from the retired register file. A producer in an earlier slot of the same group takes precedence over the rename table.

Resources come back through four inputs:
- a count of RS entries freed by dispatch,
- separate counts of load and store buffer entries released,
- a count of ROB entries retired from the oldest end of the ROB.

A flush input discards all in-flight allocations and points every register back at the retired file. With the default depth, 128 micro-ops can be in flight at once.

Top module: `uop_alloc`

## Requirements
- R1: Granted micro-ops receive consecutive ROB tags in slot order, starting at the tag after the last one granted. Tags wrap modulo ROB_DEPTH (a power of two), and the first tag after reset or flush is 0.
- R2: Slot i is granted only if slots 0..i are all valid and slots 0..i-1 are all granted. A slot with in_valid low ends the group even when later slots are valid.
- R3: No more than ROB_DEPTH micro-ops are in flight. When the ROB is full, nothing is granted until ret_n returns entries, and a group is cut to the number of free ROB entries.
- R4: No more than RS_DEPTH micro-ops hold an RS entry. When the RS is full, nothing is granted, and rs_rel frees entries for use from the next cycle onward.
- R5: in_kind encoding: 2'b01 is a load and 2'b10 is a store; 2'b00 and 2'b11 do not access memory. A load needs a free load buffer entry and a store needs a free store buffer entry. Non-memory micro-ops and the other memory kind are unaffected by a full buffer, but a blocked slot still stops every younger slot.
- R6: A source whose register has no in-flight producer reports busy low, meaning it reads the retired register file.
- R7: A source whose register was last written by an in-flight micro-op from an earlier cycle reports busy high with that micro-op's ROB tag.
- R8: A source whose register is written by an earlier slot of the same group reports busy high with the tag of the nearest such earlier slot, overriding the table.
- R9: Retiring a ROB entry clears its destination's mapping only if the mapping still holds that entry's tag. A newer mapping is kept.
- R10: During a flush cycle nothing is granted. On the next cycle all pools are fully free, every source reports busy low, and the next tag granted is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight allocations |
| in_valid | input | SLOTS | Micro-op present in each slot |
| in_kind | input | SLOTS x 2 | Memory kind per slot (01 load, 10 store) |
| in_has_dst | input | SLOTS | Slot writes a destination register |
| in_dst | input | SLOTS x log2(NREG) | Architectural destination register |
| in_src0 | input | SLOTS x log2(NREG) | First architectural source register |
| in_src1 | input | SLOTS x log2(NREG) | Second architectural source register |
| ret_n | input | log2(SLOTS+1) | Number of oldest ROB entries retiring |
| rs_rel | input | log2(DISP+1) | RS entries freed this cycle |
| lb_rel | input | log2(SLOTS+1) | Load buffer entries freed this cycle |
| sb_rel | input | log2(SLOTS+1) | Store buffer entries freed this cycle |
| grant | output | SLOTS | Slot accepted this cycle (prefix) |
| rob_tag | output | SLOTS x log2(ROB_DEPTH) | ROB tag assigned to each slot |
| src0_busy | output | SLOTS | First source comes from an in-flight entry |
| src0_tag | output | SLOTS x log2(ROB_DEPTH) | Producer tag of first source |
| src1_busy | output | SLOTS | Second source comes from an in-flight entry |
| src1_tag | output | SLOTS x log2(ROB_DEPTH) | Producer tag of second source |

## Verification
The bench fills the ROB to exactly 128 entries, frees a single one, and confirms that only slot 0 proceeds and receives tag 0. A design with an off-by-one in the capacity compare or a broken tag wrap would grant too much or hand out a stale tag. It blocks a load behind a full load buffer while a younger non-memory op and a store wait behind it. A design that skipped over the blocked slot would reorder allocation, and one that charged every micro-op a memory entry would stall the all-store group. It retires an entry whose register has since been renamed again and checks that the newer mapping survives. A design that cleared without comparing tags would send consumers to stale retired values. It also checks that a flush leaves no source pointing at a dead tag.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

  typedef enum logic [1:0] {
    K_PLAIN  = 2'b00,
    K_LOAD   = 2'b01,
    K_STORE  = 2'b10,
    K_PLAIN2 = 2'b11
  } uop_kind_e;

  function automatic logic is_load(input logic [1:0] k);
    return k == K_LOAD;
  endfunction

  function automatic logic is_store(input logic [1:0] k);
    return k == K_STORE;
  endfunction

  // cumulative demand of a prefix fits within what a pool has left
  function automatic logic fits(input int unsigned need, input int unsigned avail);
    return need <= avail;
  endfunction

endpackage

// File: rtl/alloc_pool_ctr.sv
module alloc_pool_ctr #(
  parameter int DEPTH = 32,
  parameter int TAKE_W = 3,
  parameter int GIVE_W = 3,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [TAKE_W-1:0] take,
  input  logic [GIVE_W-1:0] give,
  output logic [OW-1:0]     free_cnt
);

  logic [OW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     occ <= '0;
    else if (flush) occ <= '0;
    else            occ <= occ + OW'(take) - OW'(give);
  end

  assign free_cnt = OW'(DEPTH) - occ;

endmodule

// File: rtl/alloc_gate.sv
module alloc_gate
  import alloc_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int ROB_OW = 8,
  parameter int RS_OW  = 6,
  parameter int LB_OW  = 5,
  parameter int SB_OW  = 5,
  parameter int CW     = 3
) (
  input  logic                  flush,
  input  logic [SLOTS-1:0]      valid,
  input  logic [SLOTS-1:0][1:0] kind,
  input  logic [ROB_OW-1:0]     rob_free,
  input  logic [RS_OW-1:0]      rs_free,
  input  logic [LB_OW-1:0]      lb_free,
  input  logic [SB_OW-1:0]      sb_free,
  output logic [SLOTS-1:0]      grant,
  output logic [CW-1:0]         n_grant,
  output logic [CW-1:0]         n_load,
  output logic [CW-1:0]         n_store
);

  int unsigned need_all;
  int unsigned need_ld;
  int unsigned need_st;
  logic        still_ok;

  // prefix walk: a slot passes only if everything older passed and the
  // running demand on every pool still fits
  always_comb begin
    need_all = 0;
    need_ld  = 0;
    need_st  = 0;
    still_ok = !flush;
    grant    = '0;
    for (int i = 0; i < SLOTS; i++) begin
      need_all = need_all + 1;
      if (is_load(kind[i]))  need_ld = need_ld + 1;
      if (is_store(kind[i])) need_st = need_st + 1;
      still_ok = still_ok && valid[i]
               && fits(need_all, 32'(rob_free))
               && fits(need_all, 32'(rs_free))
               && fits(need_ld,  32'(lb_free))
               && fits(need_st,  32'(sb_free));
      grant[i] = still_ok;
    end
  end

  always_comb begin
    n_grant = '0;
    n_load  = '0;
    n_store = '0;
    for (int i = 0; i < SLOTS; i++) begin
      n_grant = n_grant + CW'(grant[i]);
      n_load  = n_load  + CW'(grant[i] && is_load(kind[i]));
      n_store = n_store + CW'(grant[i] && is_store(kind[i]));
    end
  end

endmodule

// File: rtl/alloc_rob_ring.sv
module alloc_rob_ring #(
  parameter int SLOTS = 4,
  parameter int DEPTH = 128,
  parameter int AW    = 4,
  parameter int CW    = 3,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [SLOTS-1:0]         grant,
  input  logic [CW-1:0]            n_alloc,
  input  logic [SLOTS-1:0]         has_dst,
  input  logic [SLOTS-1:0][AW-1:0] dst,
  input  logic [CW-1:0]            ret_n,
  output logic [SLOTS-1:0][TW-1:0] slot_tag,
  output logic [SLOTS-1:0]         ret_live,
  output logic [SLOTS-1:0][TW-1:0] ret_tag,
  output logic [SLOTS-1:0][AW-1:0] ret_dst
);

  logic [TW-1:0]    head;
  logic [TW-1:0]    tail;
  logic [DEPTH-1:0] dst_ok;
  logic [AW-1:0]    dst_mem [DEPTH];

  for (genvar i = 0; i < SLOTS; i++) begin : g_port
    assign slot_tag[i] = tail + TW'(i);
    assign ret_tag[i]  = head + TW'(i);
    assign ret_live[i] = (CW'(i) < ret_n) && dst_ok[ret_tag[i]];
    assign ret_dst[i]  = dst_mem[ret_tag[i]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (flush) begin
      head <= '0;
      tail <= '0;
    end else begin
      head <= head + TW'(ret_n);
      tail <= tail + TW'(n_alloc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_ok <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++)
        if (grant[i]) dst_ok[slot_tag[i]] <= has_dst[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++)
      if (grant[i]) dst_mem[slot_tag[i]] <= dst[i];
  end

endmodule

// File: rtl/alloc_rename.sv
module alloc_rename #(
  parameter int SLOTS = 4,
  parameter int NREG  = 16,
  parameter int TW    = 7,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [SLOTS-1:0]         grant,
  input  logic [SLOTS-1:0]         has_dst,
  input  logic [SLOTS-1:0][AW-1:0] dst,
  input  logic [SLOTS-1:0][AW-1:0] src0,
  input  logic [SLOTS-1:0][AW-1:0] src1,
  input  logic [SLOTS-1:0][TW-1:0] slot_tag,
  input  logic [SLOTS-1:0]         ret_live,
  input  logic [SLOTS-1:0][TW-1:0] ret_tag,
  input  logic [SLOTS-1:0][AW-1:0] ret_dst,
  output logic [SLOTS-1:0]         s0_busy,
  output logic [SLOTS-1:0][TW-1:0] s0_tag,
  output logic [SLOTS-1:0]         s1_busy,
  output logic [SLOTS-1:0][TW-1:0] s1_tag
);

  logic [NREG-1:0] map_v;
  logic [TW-1:0]   map_t [NREG];

  // table lookup, then nearer older slots of the same group override it
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      s0_busy[i] = map_v[src0[i]];
      s0_tag[i]  = map_t[src0[i]];
      s1_busy[i] = map_v[src1[i]];
      s1_tag[i]  = map_t[src1[i]];
      for (int j = 0; j < i; j++) begin
        if (has_dst[j] && dst[j] == src0[i]) begin
          s0_busy[i] = 1'b1;
          s0_tag[i]  = slot_tag[j];
        end
        if (has_dst[j] && dst[j] == src1[i]) begin
          s1_busy[i] = 1'b1;
          s1_tag[i]  = slot_tag[j];
        end
      end
    end
  end

  // retire clears first; allocations of this cycle are newer and win
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_v <= '0;
      for (int r = 0; r < NREG; r++) map_t[r] <= '0;
    end else if (flush) begin
      map_v <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++)
        if (ret_live[k] && map_v[ret_dst[k]] && map_t[ret_dst[k]] == ret_tag[k])
          map_v[ret_dst[k]] <= 1'b0;
      for (int i = 0; i < SLOTS; i++)
        if (grant[i] && has_dst[i]) begin
          map_v[dst[i]] <= 1'b1;
          map_t[dst[i]] <= slot_tag[i];
        end
    end
  end

endmodule

// File: rtl/uop_alloc.sv
module uop_alloc #(
  parameter int SLOTS     = 4,
  parameter int ROB_DEPTH = 128,
  parameter int RS_DEPTH  = 32,
  parameter int LB_DEPTH  = 16,
  parameter int SB_DEPTH  = 16,
  parameter int NREG      = 16,
  parameter int DISP      = 6,
  localparam int AW       = $clog2(NREG),
  localparam int TW       = $clog2(ROB_DEPTH),
  localparam int CW       = $clog2(SLOTS + 1),
  localparam int DW       = $clog2(DISP + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [SLOTS-1:0]         in_valid,
  input  logic [SLOTS-1:0][1:0]    in_kind,
  input  logic [SLOTS-1:0]         in_has_dst,
  input  logic [SLOTS-1:0][AW-1:0] in_dst,
  input  logic [SLOTS-1:0][AW-1:0] in_src0,
  input  logic [SLOTS-1:0][AW-1:0] in_src1,
  input  logic [CW-1:0]            ret_n,
  input  logic [DW-1:0]            rs_rel,
  input  logic [CW-1:0]            lb_rel,
  input  logic [CW-1:0]            sb_rel,
  output logic [SLOTS-1:0]         grant,
  output logic [SLOTS-1:0][TW-1:0] rob_tag,
  output logic [SLOTS-1:0]         src0_busy,
  output logic [SLOTS-1:0][TW-1:0] src0_tag,
  output logic [SLOTS-1:0]         src1_busy,
  output logic [SLOTS-1:0][TW-1:0] src1_tag
);

  localparam int ROB_OW = $clog2(ROB_DEPTH + 1);
  localparam int RS_OW  = $clog2(RS_DEPTH + 1);
  localparam int LB_OW  = $clog2(LB_DEPTH + 1);
  localparam int SB_OW  = $clog2(SB_DEPTH + 1);

  // named internal events, used by the bound checker
  logic [ROB_OW-1:0]       rob_free;
  logic [RS_OW-1:0]        rs_free;
  logic [LB_OW-1:0]        lb_free;
  logic [SB_OW-1:0]        sb_free;
  logic [CW-1:0]           n_grant;
  logic [CW-1:0]           n_load;
  logic [CW-1:0]           n_store;
  logic [SLOTS-1:0]        ret_live;
  logic [SLOTS-1:0][TW-1:0] ret_tag;
  logic [SLOTS-1:0][AW-1:0] ret_dst;

  alloc_gate #(
    .SLOTS(SLOTS), .ROB_OW(ROB_OW), .RS_OW(RS_OW),
    .LB_OW(LB_OW), .SB_OW(SB_OW), .CW(CW)
  ) u_gate (
    .flush(flush), .valid(in_valid), .kind(in_kind),
    .rob_free(rob_free), .rs_free(rs_free), .lb_free(lb_free), .sb_free(sb_free),
    .grant(grant), .n_grant(n_grant), .n_load(n_load), .n_store(n_store)
  );

  alloc_pool_ctr #(.DEPTH(ROB_DEPTH), .TAKE_W(CW), .GIVE_W(CW)) u_rob_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .take(n_grant), .give(ret_n), .free_cnt(rob_free)
  );

  alloc_pool_ctr #(.DEPTH(RS_DEPTH), .TAKE_W(CW), .GIVE_W(DW)) u_rs_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .take(n_grant), .give(rs_rel), .free_cnt(rs_free)
  );

  alloc_pool_ctr #(.DEPTH(LB_DEPTH), .TAKE_W(CW), .GIVE_W(CW)) u_lb_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .take(n_load), .give(lb_rel), .free_cnt(lb_free)
  );

  alloc_pool_ctr #(.DEPTH(SB_DEPTH), .TAKE_W(CW), .GIVE_W(CW)) u_sb_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .take(n_store), .give(sb_rel), .free_cnt(sb_free)
  );

  alloc_rob_ring #(.SLOTS(SLOTS), .DEPTH(ROB_DEPTH), .AW(AW), .CW(CW)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .grant(grant), .n_alloc(n_grant), .has_dst(in_has_dst), .dst(in_dst),
    .ret_n(ret_n), .slot_tag(rob_tag),
    .ret_live(ret_live), .ret_tag(ret_tag), .ret_dst(ret_dst)
  );

  alloc_rename #(.SLOTS(SLOTS), .NREG(NREG), .TW(TW)) u_rename (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .grant(grant), .has_dst(in_has_dst), .dst(in_dst),
    .src0(in_src0), .src1(in_src1), .slot_tag(rob_tag),
    .ret_live(ret_live), .ret_tag(ret_tag), .ret_dst(ret_dst),
    .s0_busy(src0_busy), .s0_tag(src0_tag),
    .s1_busy(src1_busy), .s1_tag(src1_tag)
  );

endmodule

// File: rtl/alloc_chk.sv
module alloc_chk #(
  parameter int SLOTS     = 4,
  parameter int ROB_DEPTH = 128,
  parameter int RS_DEPTH  = 32,
  parameter int LB_DEPTH  = 16,
  parameter int SB_DEPTH  = 16,
  localparam int TW       = $clog2(ROB_DEPTH),
  localparam int CW       = $clog2(SLOTS + 1),
  localparam int ROB_OW   = $clog2(ROB_DEPTH + 1),
  localparam int RS_OW    = $clog2(RS_DEPTH + 1),
  localparam int LB_OW    = $clog2(LB_DEPTH + 1),
  localparam int SB_OW    = $clog2(SB_DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush,
  input logic [SLOTS-1:0]         grant,
  input logic [SLOTS-1:0][TW-1:0] rob_tag,
  input logic [CW-1:0]            n_grant,
  input logic [CW-1:0]            n_load,
  input logic [CW-1:0]            n_store,
  input logic [ROB_OW-1:0]        rob_free,
  input logic [RS_OW-1:0]         rs_free,
  input logic [LB_OW-1:0]         lb_free,
  input logic [SB_OW-1:0]         sb_free
);

  // R1
  tag_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> rob_tag[0] == $past(rob_tag[0]) + TW'($past(n_grant)));

  // R2
  grant_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant + SLOTS'(1)) & grant) == '0);

  // R3
  rob_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rob_free == '0 |-> grant == '0);

  // R3
  rob_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(n_grant) <= 32'(rob_free));

  // R4
  rs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_free == '0 |-> grant == '0);

  // R5
  lb_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_free == '0 |-> n_load == '0);

  // R5
  sb_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_free == '0 |-> n_store == '0);

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> grant == '0);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> rob_free == ROB_OW'(ROB_DEPTH) && rs_free == RS_OW'(RS_DEPTH)
           && lb_free == LB_OW'(LB_DEPTH) && sb_free == SB_OW'(SB_DEPTH)
           && rob_tag[0] == '0);

endmodule

bind uop_alloc alloc_chk #(
  .SLOTS(SLOTS), .ROB_DEPTH(ROB_DEPTH), .RS_DEPTH(RS_DEPTH),
  .LB_DEPTH(LB_DEPTH), .SB_DEPTH(SB_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .grant(grant), .rob_tag(rob_tag),
  .n_grant(n_grant), .n_load(n_load), .n_store(n_store),
  .rob_free(rob_free), .rs_free(rs_free), .lb_free(lb_free), .sb_free(sb_free)
);

// File: tb/uop_alloc_bench.sv
module uop_alloc_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush;
  logic [3:0]      valid;
  logic [3:0][1:0] kind;
  logic [3:0]      hasdst;
  logic [3:0][3:0] dst, src0, src1;
  logic [2:0]      ret_n, rs_rel, lb_rel, sb_rel;
  logic [3:0]      grant;
  logic [3:0][6:0] rob_tag, s0t, s1t;
  logic [3:0]      s0b, s1b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uop_alloc u_uop_alloc (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(valid), .in_kind(kind), .in_has_dst(hasdst), .in_dst(dst),
    .in_src0(src0), .in_src1(src1),
    .ret_n(ret_n), .rs_rel(rs_rel), .lb_rel(lb_rel), .sb_rel(sb_rel),
    .grant(grant), .rob_tag(rob_tag),
    .src0_busy(s0b), .src0_tag(s0t), .src1_busy(s1b), .src1_tag(s1t)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; valid = '0; kind = '0; hasdst = '0;
    dst = '0; src0 = '0; src1 = '0;
    ret_n = '0; rs_rel = '0; lb_rel = '0; sb_rel = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_flush();
    idle();
    flush = 1'b1;
    valid = '1;
    #1;
    chk("R10", "grant in flush cycle", 32'(grant), 32'h0);
    tick();
    idle();
  endtask

  task automatic t_reset();
    idle();
    src0[0] = 4'd3;
    #1;
    chk("R2", "no valid slots, no grant", 32'(grant), 32'h0);
    chk("R6", "src after reset busy", 32'(s0b[0]), 32'h0);
  endtask

  task automatic t_rename();
    do_flush();
    valid = '1;
    hasdst = 4'b0111;
    dst[0] = 4'd5; dst[1] = 4'd6; dst[2] = 4'd5;
    src0[1] = 4'd5; src1[3] = 4'd5; src0[3] = 4'd6;
    #1;
    chk("R1", "group A grant", 32'(grant), 32'hF);
    chk("R1", "slot3 tag", 32'(rob_tag[3]), 32'd3);
    chk("R6", "slot0 reg0 busy", 32'(s0b[0]), 32'h0);
    chk("R8", "slot1 src0 busy", 32'(s0b[1]), 32'h1);
    chk("R8", "slot1 src0 tag", 32'(s0t[1]), 32'd0);
    chk("R8", "slot3 src1 nearest tag", 32'(s1t[3]), 32'd2);
    chk("R8", "slot3 src0 tag", 32'(s0t[3]), 32'd1);
    tick();
    idle();
    valid = 4'b0001; src0[0] = 4'd5; src1[0] = 4'd6;
    #1;
    chk("R1", "group B tag", 32'(rob_tag[0]), 32'd4);
    chk("R7", "src0 busy", 32'(s0b[0]), 32'h1);
    chk("R7", "src0 tag", 32'(s0t[0]), 32'd2);
    chk("R7", "src1 tag", 32'(s1t[0]), 32'd1);
    tick();
    idle();
    ret_n = 3'd1;
    tick();
    idle();
    src0[0] = 4'd5; src1[0] = 4'd6; ret_n = 3'd2;
    #1;
    chk("R9", "newer map kept busy", 32'(s0b[0]), 32'h1);
    chk("R9", "newer map kept tag", 32'(s0t[0]), 32'd2);
    tick();
    idle();
    src0[0] = 4'd5; src1[0] = 4'd6;
    #1;
    chk("R9", "reg5 cleared", 32'(s0b[0]), 32'h0);
    chk("R9", "reg6 cleared", 32'(s1b[0]), 32'h0);
    idle();
    valid = 4'b1011;
    #1;
    chk("R2", "gap stops group", 32'(grant), 32'h3);
    idle();
  endtask

  task automatic t_flush();
    do_flush();
    valid = 4'b0001; hasdst = 4'b0001; dst[0] = 4'd9;
    tick();
    idle();
    do_flush();
    src0[0] = 4'd9; valid = 4'b0001;
    #1;
    chk("R10", "src after flush busy", 32'(s0b[0]), 32'h0);
    chk("R10", "tag restarts", 32'(rob_tag[0]), 32'd0);
    idle();
  endtask

  task automatic t_rob_full();
    do_flush();
    for (int c = 0; c < 32; c++) begin
      valid = '1;
      rs_rel = (c == 0) ? 3'd0 : 3'd4;
      tick();
    end
    idle();
    valid = '1;
    #1;
    chk("R3", "rob full grant", 32'(grant), 32'h0);
    idle();
    ret_n = 3'd1;
    tick();
    idle();
    valid = '1;
    #1;
    chk("R3", "one rob entry back", 32'(grant), 32'h1);
    chk("R1", "tag wraps to 0", 32'(rob_tag[0]), 32'd0);
    idle();
  endtask

  task automatic t_rs_full();
    do_flush();
    for (int c = 0; c < 8; c++) begin
      valid = '1;
      tick();
    end
    idle();
    valid = '1;
    #1;
    chk("R4", "rs full grant", 32'(grant), 32'h0);
    idle();
    rs_rel = 3'd2;
    tick();
    idle();
    valid = '1;
    #1;
    chk("R4", "two rs entries back", 32'(grant), 32'h3);
    idle();
  endtask

  task automatic t_mem();
    do_flush();
    for (int c = 0; c < 4; c++) begin
      valid = '1;
      kind = {2'b01, 2'b01, 2'b01, 2'b01};
      tick();
    end
    idle();
    valid = '1;
    kind[0] = 2'b00; kind[1] = 2'b01; kind[2] = 2'b00; kind[3] = 2'b10;
    #1;
    chk("R5", "load blocks younger", 32'(grant), 32'h1);
    kind[0] = 2'b00; kind[1] = 2'b10; kind[2] = 2'b10; kind[3] = 2'b11;
    #1;
    chk("R5", "stores and plain pass", 32'(grant), 32'hF);
    idle();
    lb_rel = 3'd1;
    tick();
    idle();
    valid = 4'b0011;
    kind[0] = 2'b01; kind[1] = 2'b01;
    #1;
    chk("R5", "one load entry back", 32'(grant), 32'h1);
    idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    t_reset();
    t_rename();
    t_flush();
    t_rob_full();
    t_rs_full();
    t_mem();
    tick();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule